// File: doc/BRIEF.md
# SDI scrambler and NRZI serializer

This block turns 10-bit parallel video words into one serial bitstream of the kind used on standard-definition serial digital video links. A word and a one-cycle strobe are presented once every ten cycles of the bit clock. The bit clock is supplied from outside at ten times the word rate. Each word is shifted out least-significant bit first. The bits pass through a self-synchronizing scrambler with generator x^9 + x^4 + 1, and then through an NRZI coder. A bypass control sends the raw bits straight to the output.

A detector watches the incoming words for the timing-reference preamble, which is one all-ones word followed by two all-zeros words. A disable input suppresses the detection. When the block carries 8-bit formats, a mode input forces any word whose upper eight bits are all ones to all ones, and any word whose upper eight bits are all zeros to all zeros. The forced value is used both for serializing and for detection.

Top module: `sdi_serializer`

## Requirements
- R1: While reset is held, and after it is released, ser_out and trs_det are 0. The scrambler history and the NRZI level start at 0. The block starts working on the third rising clock edge after rst_n goes high.
- R2: A word strobed in cycle t is serialized least-significant bit first. The value derived from bit k is visible on ser_out during cycle t+2+k, for k from 0 to 9.
- R3: A strobe in cycle t+10 follows the last bit of the word strobed in cycle t with no gap. Strobes every ten cycles therefore give a continuous bitstream.
- R4: Each scrambled bit equals the raw bit XOR the scrambled bits produced 4 and 9 bit positions earlier. This history continues across word boundaries.
- R5: Outside bypass, ser_out toggles when the scrambled bit is 1 and holds when it is 0.
- R6: While bypass is 1 during a bit cycle, ser_out carries the raw bit. The scrambler history and the NRZI level keep advancing as if bypass were 0, so coding resumes seamlessly when bypass returns to 0.
- R7: When no bits are pending, ser_out holds its value and the coder state stays frozen until the next strobe.
- R8: A strobe that arrives while more than one bit of the current word remains emits the current bit, then drops the rest of that word and starts the new word.
- R9: trs_det is high for exactly cycle t+1 when the word strobed in cycle t is 000 and the two previously strobed words were 3FF and then 000. trs_det is 0 in every other cycle.
- R10: sync_dis high in a strobe cycle suppresses trs_det for that word. The word still enters the detector history.
- R11: With mode8 at 1, a word with bits 9:2 all ones is treated as 3FF, and a word with bits 9:2 all zeros is treated as 000, for both serializing and detection. With mode8 at 0, words are used unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, ten times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_stb | input | 1 | One-cycle strobe marking word_in as valid |
| word_in | input | 10 | Parallel video word |
| mode8 | input | 1 | 1 selects 8-bit format conditioning |
| bypass | input | 1 | 1 sends raw bits to the output, without scrambling or NRZI |
| sync_dis | input | 1 | 1 suppresses timing-reference detection |
| ser_out | output | 1 | Serial bitstream |
| trs_det | output | 1 | One-cycle pulse on a detected timing-reference preamble |

## Verification
Two things land on the same clock edge. The strobe that loads the next word coincides with the emission of the previous word's tenth bit, and a reload can also cut short a word that is still in progress. The bench provokes the first with strobes exactly ten cycles apart, and the second with strobes only four cycles apart. Bypass is flipped in the middle of a word, so that the raw and coded paths alternate while the scrambler history keeps running. A behavioural model holds the pending bits and the scrambled history in queues, and every output is judged against it on every cycle.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;
  localparam int WORD_W   = 10;  // parallel word width
  localparam int HDR_W    = 8;   // upper bits examined in 8-bit mode
  localparam int TAP_NEAR = 4;   // x^4 term
  localparam int TAP_FAR  = 9;   // x^9 term, also history length
endpackage

// File: rtl/sdi_word_cond.sv
module sdi_word_cond
  import sdi_ser_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int HI = HDR_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         word_stb,
  input  logic [W-1:0] word_in,
  input  logic         mode8,
  input  logic         sync_dis,
  output logic [W-1:0] word_c,
  output logic         trs_q
);
  localparam int LO = W - HI;

  logic         hi_ones, hi_zero;
  logic [W-1:0] hist1_q, hist2_q, hist1_d, hist2_d;
  logic         trs_d;

  assign hi_ones = &word_in[W-1:LO];
  assign hi_zero = ~|word_in[W-1:LO];

  always_comb begin
    word_c = word_in;
    if (mode8 && hi_ones)      word_c = '1;
    else if (mode8 && hi_zero) word_c = '0;
  end

  always_comb begin
    hist1_d = hist1_q;
    hist2_d = hist2_q;
    trs_d   = 1'b0;
    if (word_stb) begin
      hist1_d = word_c;
      hist2_d = hist1_q;
      trs_d   = !sync_dis && (&hist2_q) && (hist1_q == '0) && (word_c == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist1_q <= '0;
      hist2_q <= '0;
      trs_q   <= 1'b0;
    end else begin
      hist1_q <= hist1_d;
      hist2_q <= hist2_d;
      trs_q   <= trs_d;
    end
  end

  AST_TRS_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_ni)
    trs_q |-> $past(word_stb)); // R9
  AST_SYNC_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    sync_dis |=> !trs_q); // R10
endmodule

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter
  import sdi_ser_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] word_c,
  output logic         bit_en,
  output logic         raw_bit
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg_q, shreg_d;
  logic [CW-1:0] left_q, left_d;

  assign bit_en  = (left_q != '0);
  assign raw_bit = shreg_q[0];

  always_comb begin
    shreg_d = shreg_q;
    left_d  = left_q;
    if (load) begin
      shreg_d = word_c;
      left_d  = CW'(W);
    end else if (bit_en) begin
      shreg_d = {1'b0, shreg_q[W-1:1]};
      left_d  = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
    end
  end

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> (left_q == CW'(W))); // R8
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    !load && bit_en |=> (left_q < CW'(W))); // R3
endmodule

// File: rtl/sdi_scr_nrzi.sv
module sdi_scr_nrzi
  import sdi_ser_pkg::*;
#(
  parameter int T_NEAR = TAP_NEAR,
  parameter int T_FAR  = TAP_FAR
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_en,
  input  logic raw_bit,
  input  logic bypass,
  output logic ser_q
);
  logic [T_FAR-1:0] scr_q, scr_d;
  logic             nrzi_q, nrzi_d;
  logic             ser_d;
  logic             scr_bit;

  assign scr_bit = raw_bit ^ scr_q[T_NEAR-1] ^ scr_q[T_FAR-1];

  always_comb begin
    scr_d  = scr_q;
    nrzi_d = nrzi_q;
    ser_d  = ser_q;
    if (bit_en) begin
      scr_d  = {scr_q[T_FAR-2:0], scr_bit};
      nrzi_d = nrzi_q ^ scr_bit;
      ser_d  = bypass ? raw_bit : (nrzi_q ^ scr_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scr_q  <= '0;
      nrzi_q <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      scr_q  <= scr_d;
      nrzi_q <= nrzi_d;
      ser_q  <= ser_d;
    end
  end

  AST_NRZI_FOLLOWS_SCR: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_en |=> (nrzi_q == ($past(nrzi_q) ^ scr_q[0]))); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    !bit_en |=> $stable(ser_q) && $stable(scr_q) && $stable(nrzi_q)); // R7
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
  import sdi_ser_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int HI     = HDR_W,
  parameter int T_NEAR = TAP_NEAR,
  parameter int T_FAR  = TAP_FAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic [W-1:0] word_in,
  input  logic         mode8,
  input  logic         bypass,
  input  logic         sync_dis,
  output logic         ser_out,
  output logic         trs_det
);
  logic [1:0]   rsync_q;
  logic         rst_i;
  logic [W-1:0] word_c;
  logic         bit_en, raw_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  sdi_word_cond #(.W(W), .HI(HI)) cond_i (
    .clk(clk), .rst_ni(rst_i), .word_stb(word_stb), .word_in(word_in),
    .mode8(mode8), .sync_dis(sync_dis), .word_c(word_c), .trs_q(trs_det)
  );

  sdi_word_shifter #(.W(W)) shift_i (
    .clk(clk), .rst_ni(rst_i), .load(word_stb), .word_c(word_c),
    .bit_en(bit_en), .raw_bit(raw_bit)
  );

  sdi_scr_nrzi #(.T_NEAR(T_NEAR), .T_FAR(T_FAR)) coder_i (
    .clk(clk), .rst_ni(rst_i), .bit_en(bit_en), .raw_bit(raw_bit),
    .bypass(bypass), .ser_q(ser_out)
  );

  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_i)
    bit_en && bypass |=> (ser_out == $past(raw_bit))); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i |-> !ser_out && !trs_det); // R1
endmodule

// File: tb/sdi_serializer_tb_top.sv
module sdi_serializer_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, word_stb, mode8, bypass, sync_dis;
  logic [9:0] word_in;
  logic       ser_out, trs_det;

  int    total = 0;
  int    bad   = 0;
  bit    chk_on = 0;
  string req = "R1";

  bit   pend[$];
  bit   shist[$];
  bit   m_nrzi = 0;
  bit   exp_ser = 0;
  bit   exp_trs = 0;
  logic [9:0] h1 = 0, h2 = 0;
  int   rcnt = 0;

  always #(PERIOD/2) clk = ~clk;

  sdi_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_in(word_in),
    .mode8(mode8), .bypass(bypass), .sync_dis(sync_dis),
    .ser_out(ser_out), .trs_det(trs_det)
  );

  function automatic logic [9:0] cond_w(logic [9:0] w, logic m8);
    if (m8 && w[9:2] == 8'hFF) return 10'h3FF;
    if (m8 && w[9:2] == 8'h00) return 10'h000;
    return w;
  endfunction

  task automatic model_reset();
    pend.delete();
    shist.delete();
    for (int i = 0; i < 9; i++) shist.push_back(1'b0);
    m_nrzi = 0; exp_ser = 0; exp_trs = 0; h1 = 0; h2 = 0;
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; model_reset();
    end else if (rcnt < 2) begin
      rcnt++; model_reset();
    end else begin
      bit b, s;
      logic [9:0] c;
      if (pend.size() > 0) begin
        b = pend.pop_front();
        s = b ^ shist[3] ^ shist[8];
        m_nrzi = m_nrzi ^ s;
        shist.push_front(s);
        void'(shist.pop_back());
        exp_ser = bypass ? b : m_nrzi;
      end
      exp_trs = 0;
      if (word_stb) begin
        c = cond_w(word_in, mode8);
        exp_trs = !sync_dis && h2 == 10'h3FF && h1 == 10'h000 && c == 10'h000;
        h2 = h1; h1 = c;
        pend.delete();
        for (int k = 0; k < 10; k++) pend.push_back(c[k]);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      total++;
      if (ser_out !== exp_ser) begin
        bad++;
        $display("FAIL %s ser_out act=%0b exp=%0b t=%0t", req, ser_out, exp_ser, $time);
      end
      total++;
      if (trs_det !== exp_trs) begin
        bad++;
        $display("FAIL %s trs_det act=%0b exp=%0b t=%0t", req, trs_det, exp_trs, $time);
      end
    end
  end

  task automatic send(logic [9:0] w, int gap);
    word_in = w; word_stb = 1;
    @(negedge clk);
    word_stb = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_bp_flip(logic [9:0] w);
    word_in = w; word_stb = 1;
    @(negedge clk);
    word_stb = 0;
    repeat (4) @(negedge clk);
    bypass = ~bypass;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1; word_stb = 0; word_in = 0; mode8 = 0; bypass = 0; sync_dis = 0;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk_on = 1; req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // raw bit order first, through bypass
    req = "R2"; bypass = 1;
    send(10'h001, 10); send(10'h200, 10); send(10'h2A5, 10); send(10'h0F3, 10);
    // coded stream, back-to-back words
    bypass = 0; req = "R4";
    send(10'h001, 10); send(10'h000, 10); send(10'h000, 10);
    req = "R5";
    send(10'h3FF, 10); send(10'h155, 10); send(10'h2AA, 10); send(10'h0C3, 10);
    req = "R3";
    for (int i = 0; i < 8; i++) send(10'((i * 97 + 13) % 1024), 10);
    // idle gap
    req = "R7";
    send(10'h1B6, 35);
    send(10'h06D, 10);
    // bypass changed mid-word and then released
    req = "R6";
    send_bp_flip(10'h3C5); send_bp_flip(10'h13A); send_bp_flip(10'h2F0); send_bp_flip(10'h0BD);
    bypass = 0;
    send(10'h111, 10);
    // early reloads
    req = "R8";
    send(10'h3E7, 4); send(10'h081, 3); send(10'h2D2, 10);
    // timing-reference detection
    req = "R9";
    send(10'h3FF, 10); send(10'h000, 10); send(10'h000, 10); send(10'h2DA, 10);
    send(10'h000, 10); send(10'h3FF, 10); send(10'h000, 10); send(10'h004, 10);
    send(10'h3FF, 10); send(10'h000, 4); send(10'h000, 10);
    req = "R10";
    send(10'h3FF, 10); send(10'h000, 10); sync_dis = 1; send(10'h000, 10);
    sync_dis = 0; send(10'h000, 10);
    // 8-bit conditioning
    req = "R11";
    mode8 = 1;
    send(10'h3FD, 10); send(10'h001, 10); send(10'h002, 10); send(10'h3FC, 10);
    send(10'h203, 10);
    mode8 = 0;
    send(10'h3FD, 10); send(10'h000, 10); send(10'h000, 10);
    send(10'h3FF, 10); send(10'h001, 10); send(10'h000, 10);
    req = "R7";
    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule